// File: doc/BRIEF.md
# Priority-Overtaking Packet Forwarding Node

This block is one hop of a point-to-point real-time network. Fixed 8-byte packets come in byte by byte from two places: a local injection port and an upstream link. They leave on a single downstream link. Each packet carries a 2-bit priority in the low bits of its first byte. The node files every packet into a queue for its priority. It always sends the oldest complete packet from the highest non-empty queue, so urgent traffic overtakes bulk traffic that arrived earlier. Arbitration happens only between packets. Once a packet has started on the output, it runs to its last byte.

Both input ports use a valid/ready handshake. A source is refused, and not dropped, when the queue for its packet's priority has no free packet slot. The other source may be served while it waits. The two sources alternate whenever both have a packet waiting. The output has a registered valid/ready stage with start and end flags.

Event signals travel on their own narrow path. It is a fixed chain of registers, so an event crosses the node in a constant number of cycles whatever the data traffic is doing.

Top module: `prio_fwd_node`

## Requirements
- R1: After a synchronous reset, out_valid is low and ev_out is zero, and neither input asserts ready while its own valid is low.
- R2: Every packet leaves as exactly 8 bytes in the order they were received. out_sop is high only on byte 0 and out_eop only on byte 7.
- R3: The priority of a packet is bits [1:0] of its byte 0, and value 3 is the most urgent. When the output picks a new packet, it takes one from the highest-priority queue that holds a complete packet.
- R4: Packets of equal priority leave in the order in which their first bytes were accepted.
- R5: A packet already started on the output is finished before any other packet is started, even if a more urgent one arrives meanwhile.
- R6: Each priority queue holds 2 whole packets, counting one being sent. A source whose next packet maps to a full queue sees ready low and keeps its packet. A packet of another priority on the other source is still accepted meanwhile, and the held packet is delivered later.
- R7: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop hold their values.
- R8: At most one input is ready in any cycle. The input side changes source only after byte 7 of a packet, and it alternates between the sources when both have a packet waiting.
- R9: ev_out equals the bitwise OR of ev_loc and ev_lnk_in as it was exactly HOPS cycles earlier (3 by default), independent of packet traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local injection byte valid |
| loc_ready | output | 1 | Local injection byte accepted this cycle |
| loc_data | input | DW | Local injection byte |
| lnk_valid | input | 1 | Upstream link byte valid |
| lnk_ready | output | 1 | Upstream link byte accepted this cycle |
| lnk_data | input | DW | Upstream link byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | DW | Downstream byte |
| out_sop | output | 1 | Marks byte 0 of a packet |
| out_eop | output | 1 | Marks byte 7 of a packet |
| ev_loc | input | EW | Locally raised event bits |
| ev_lnk_in | input | EW | Event bits from the upstream node |
| ev_out | output | EW | Event bits to the downstream node |

## Verification
A single packet sent on each source with the output free checks framing and byte order with no contention. Mixed priorities queued behind a stalled output separate strict priority selection from arrival order. The packet that had already entered the output register shows that a started packet is not preempted. A run of equal-priority packets from both sources separates FIFO order from priority order. A fourth packet aimed at a full queue, with a packet of another priority on the other port, shows refusal without loss and that one full queue does not block the other. Both sources starting at once show alternation. An event pattern driven during traffic shows the fixed hop delay is untouched by data flow.

// File: rtl/prio_node_pkg.sv
package prio_node_pkg;
  typedef enum logic {SRC_LOC = 1'b0, SRC_LNK = 1'b1} src_e;
endpackage

// File: rtl/pn_queue.sv
// One priority queue: packet-granular slots in an inferred RAM.
// DEPTH_PKTS and PKT_BYTES must be powers of two, both at least 2.
module pn_queue #(
  parameter int DW         = 8,
  parameter int PKT_BYTES  = 8,
  parameter int DEPTH_PKTS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          wr_first,
  input  logic                          wr_last,
  input  logic [$clog2(PKT_BYTES)-1:0]  wr_off,
  input  logic [DW-1:0]                 wr_data,
  input  logic [$clog2(PKT_BYTES)-1:0]  rd_off,
  input  logic                          rd_pop,
  output logic [DW-1:0]                 rd_data,
  output logic                          has_pkt,
  output logic                          has_room
);
  localparam int OFF_W  = $clog2(PKT_BYTES);
  localparam int SLOT_W = $clog2(DEPTH_PKTS);
  localparam int CNT_W  = $clog2(DEPTH_PKTS + 1);
  localparam int WORDS  = DEPTH_PKTS * PKT_BYTES;

  logic [DW-1:0]     mem [WORDS];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [CNT_W-1:0]  n_alloc, n_done;
  logic              alloc_inc, done_inc;

  assign alloc_inc = wr_en && wr_first;
  assign done_inc  = wr_en && wr_last;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_slot, wr_off}] <= wr_data;
  end

  assign rd_data  = mem[{rd_slot, rd_off}];
  assign has_pkt  = (n_done != '0);
  assign has_room = (n_alloc < CNT_W'(DEPTH_PKTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot <= '0;
      rd_slot <= '0;
      n_alloc <= '0;
      n_done  <= '0;
    end else begin
      if (done_inc) wr_slot <= wr_slot + SLOT_W'(1);
      if (rd_pop)   rd_slot <= rd_slot + SLOT_W'(1);
      case ({alloc_inc, rd_pop})
        2'b10:   n_alloc <= n_alloc + CNT_W'(1);
        2'b01:   n_alloc <= n_alloc - CNT_W'(1);
        default: n_alloc <= n_alloc;
      endcase
      case ({done_inc, rd_pop})
        2'b10:   n_done <= n_done + CNT_W'(1);
        2'b01:   n_done <= n_done - CNT_W'(1);
        default: n_done <= n_done;
      endcase
    end
  end
endmodule

// File: rtl/pn_in_arb.sv
// Input side: picks one source per packet and steers bytes to a queue.
module pn_in_arb
  import prio_node_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PKT_BYTES = 8,
  parameter int NUM_PRIO  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          loc_valid,
  input  logic [DW-1:0]                 loc_data,
  output logic                          loc_ready,
  input  logic                          lnk_valid,
  input  logic [DW-1:0]                 lnk_data,
  output logic                          lnk_ready,
  input  logic [NUM_PRIO-1:0]           room,
  output logic [NUM_PRIO-1:0]           q_wr_en,
  output logic                          wr_first,
  output logic                          wr_last,
  output logic [$clog2(PKT_BYTES)-1:0]  wr_off,
  output logic [DW-1:0]                 wr_data
);
  localparam int OFF_W = $clog2(PKT_BYTES);
  localparam int PW    = $clog2(NUM_PRIO);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(PKT_BYTES - 1);

  logic             busy;
  src_e             cur_src, pref, sel_src;
  logic [PW-1:0]    cur_prio, prio_w;
  logic [OFF_W-1:0] cnt;
  logic             loc_ok, lnk_ok, take;

  assign loc_ok = loc_valid && room[loc_data[PW-1:0]];
  assign lnk_ok = lnk_valid && room[lnk_data[PW-1:0]];

  always_comb begin
    if (busy) begin
      loc_ready = (cur_src == SRC_LOC);
      lnk_ready = (cur_src == SRC_LNK);
    end else if (pref == SRC_LNK) begin
      lnk_ready = lnk_ok;
      loc_ready = loc_ok && !lnk_ok;
    end else begin
      loc_ready = loc_ok;
      lnk_ready = lnk_ok && !loc_ok;
    end
  end

  assign sel_src  = busy ? cur_src : (lnk_ready ? SRC_LNK : SRC_LOC);
  assign take     = (sel_src == SRC_LNK) ? (lnk_valid && lnk_ready) : (loc_valid && loc_ready);
  assign wr_data  = (sel_src == SRC_LNK) ? lnk_data : loc_data;
  assign prio_w   = busy ? cur_prio : wr_data[PW-1:0];
  assign wr_off   = busy ? cnt : '0;
  assign wr_first = take && !busy;
  assign wr_last  = take && (wr_off == LAST);

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_wen
    assign q_wr_en[g] = take && (prio_w == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_src  <= SRC_LOC;
      pref     <= SRC_LOC;
      cur_prio <= '0;
      cnt      <= '0;
    end else if (take) begin
      if (wr_off == LAST) begin
        busy <= 1'b0;
        pref <= (sel_src == SRC_LNK) ? SRC_LOC : SRC_LNK;
      end else begin
        busy     <= 1'b1;
        cur_src  <= sel_src;
        cur_prio <= prio_w;
        cnt      <= wr_off + OFF_W'(1);
      end
    end
  end
endmodule

// File: rtl/pn_out_sched.sv
// Output side: strict-priority pick at packet boundaries, registered byte stage.
module pn_out_sched #(
  parameter int DW        = 8,
  parameter int PKT_BYTES = 8,
  parameter int NUM_PRIO  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PRIO-1:0]           has_pkt,
  input  logic [DW-1:0]                 rd_byte,
  output logic [$clog2(NUM_PRIO)-1:0]   rd_sel,
  output logic [$clog2(PKT_BYTES)-1:0]  rd_off,
  output logic [NUM_PRIO-1:0]           pop,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [DW-1:0]                 out_data,
  output logic                          out_sop,
  output logic                          out_eop
);
  localparam int OFF_W = $clog2(PKT_BYTES);
  localparam int PW    = $clog2(NUM_PRIO);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(PKT_BYTES - 1);

  logic             busy, load, go;
  logic [PW-1:0]    cur, pick;
  logic [OFF_W-1:0] cnt;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_PRIO; i++) begin
      if (has_pkt[i]) pick = PW'(i);
    end
  end

  assign load   = !out_valid || out_ready;
  assign rd_sel = busy ? cur : pick;
  assign rd_off = busy ? cnt : '0;
  assign go     = load && (busy || (|has_pkt));

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_pop
    assign pop[g] = go && (rd_off == LAST) && (rd_sel == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      busy      <= 1'b0;
      cur       <= '0;
      cnt       <= '0;
    end else if (load) begin
      out_valid <= go;
      if (go) begin
        out_data <= rd_byte;
        out_sop  <= (rd_off == '0);
        out_eop  <= (rd_off == LAST);
        if (rd_off == LAST) begin
          busy <= 1'b0;
        end else begin
          busy <= 1'b1;
          cur  <= rd_sel;
          cnt  <= rd_off + OFF_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pn_event_delay.sv
// Fixed-latency event path: HOPS register stages, no interaction with data.
module pn_event_delay #(
  parameter int EW   = 4,
  parameter int HOPS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] ev_in,
  output logic [EW-1:0] ev_out
);
  logic [EW-1:0] stg [HOPS];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= ev_in;
  end

  for (genvar g = 1; g < HOPS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign ev_out = stg[HOPS-1];
endmodule

// File: rtl/prio_fwd_node.sv
module prio_fwd_node #(
  parameter int DW         = 8,
  parameter int PKT_BYTES  = 8,
  parameter int NUM_PRIO   = 4,
  parameter int DEPTH_PKTS = 2,
  parameter int EW         = 4,
  parameter int HOPS       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_valid,
  output logic          loc_ready,
  input  logic [DW-1:0] loc_data,
  input  logic          lnk_valid,
  output logic          lnk_ready,
  input  logic [DW-1:0] lnk_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  input  logic [EW-1:0] ev_loc,
  input  logic [EW-1:0] ev_lnk_in,
  output logic [EW-1:0] ev_out
);
  localparam int OFF_W = $clog2(PKT_BYTES);
  localparam int PW    = $clog2(NUM_PRIO);

  logic [NUM_PRIO-1:0] q_room, q_pkt, q_wr_en, q_pop;
  logic [DW-1:0]       q_rd [NUM_PRIO];
  logic                wr_first, wr_last;
  logic [OFF_W-1:0]    wr_off, rd_off;
  logic [DW-1:0]       wr_data;
  logic [PW-1:0]       rd_sel;

  pn_in_arb #(.DW(DW), .PKT_BYTES(PKT_BYTES), .NUM_PRIO(NUM_PRIO)) u_in (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_ready(loc_ready),
    .lnk_valid(lnk_valid), .lnk_data(lnk_data), .lnk_ready(lnk_ready),
    .room(q_room), .q_wr_en(q_wr_en), .wr_first(wr_first), .wr_last(wr_last),
    .wr_off(wr_off), .wr_data(wr_data)
  );

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_q
    pn_queue #(.DW(DW), .PKT_BYTES(PKT_BYTES), .DEPTH_PKTS(DEPTH_PKTS)) u_q (
      .clk(clk), .rst(rst),
      .wr_en(q_wr_en[g]), .wr_first(wr_first), .wr_last(wr_last),
      .wr_off(wr_off), .wr_data(wr_data),
      .rd_off(rd_off), .rd_pop(q_pop[g]), .rd_data(q_rd[g]),
      .has_pkt(q_pkt[g]), .has_room(q_room[g])
    );
  end

  pn_out_sched #(.DW(DW), .PKT_BYTES(PKT_BYTES), .NUM_PRIO(NUM_PRIO)) u_out (
    .clk(clk), .rst(rst),
    .has_pkt(q_pkt), .rd_byte(q_rd[rd_sel]), .rd_sel(rd_sel), .rd_off(rd_off),
    .pop(q_pop), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  pn_event_delay #(.EW(EW), .HOPS(HOPS)) u_ev (
    .clk(clk), .rst(rst), .ev_in(ev_loc | ev_lnk_in), .ev_out(ev_out)
  );
endmodule

// File: rtl/pn_checker.sv
module pn_checker #(
  parameter int DW         = 8,
  parameter int PKT_BYTES  = 8,
  parameter int NUM_PRIO   = 4,
  parameter int DEPTH_PKTS = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          loc_valid,
  input logic          loc_ready,
  input logic          lnk_valid,
  input logic          lnk_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sop,
  input logic          out_eop
);
  int   ob_cnt, ib_cnt, pend;
  logic in_acc, out_fire, in_sop, out_done;

  assign in_acc   = (loc_valid && loc_ready) || (lnk_valid && lnk_ready);
  assign out_fire = out_valid && out_ready;
  assign in_sop   = in_acc && (ib_cnt == 0);
  assign out_done = out_fire && out_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_cnt <= 0;
      ib_cnt <= 0;
      pend   <= 0;
    end else begin
      if (out_fire) ob_cnt <= out_eop ? 0 : ob_cnt + 1;
      if (in_acc)   ib_cnt <= (ib_cnt == PKT_BYTES - 1) ? 0 : ib_cnt + 1;
      pend <= pend + int'(in_sop) - int'(out_done);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R7
  AST_ONE_READY: assert property (@(posedge clk) disable iff (rst)
    !(loc_ready && lnk_ready)); // R8
  AST_SOP_POS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sop == (ob_cnt == 0))); // R2
  AST_EOP_POS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_eop == (ob_cnt == PKT_BYTES - 1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pend <= NUM_PRIO * DEPTH_PKTS + 1); // R6
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (pend > 0)); // R2
endmodule

bind prio_fwd_node pn_checker #(
  .DW(DW), .PKT_BYTES(PKT_BYTES), .NUM_PRIO(NUM_PRIO), .DEPTH_PKTS(DEPTH_PKTS)
) u_chk (
  .clk(clk), .rst(rst),
  .loc_valid(loc_valid), .loc_ready(loc_ready),
  .lnk_valid(lnk_valid), .lnk_ready(lnk_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/sim_prio_fwd_node.sv
module sim_prio_fwd_node;
  localparam int DW = 8, PB = 8, NP = 4, QD = 2, EW = 4, HOPS = 3;

  logic          clk = 1'b0, rst = 1'b1;
  logic          loc_valid = 1'b0, lnk_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] loc_data = '0, lnk_data = '0;
  logic          loc_ready, lnk_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [EW-1:0] ev_loc = '0, ev_lnk_in = '0, ev_out;

  always #2 clk = ~clk;

  prio_fwd_node #(.DW(DW), .PKT_BYTES(PB), .NUM_PRIO(NP), .DEPTH_PKTS(QD),
                  .EW(EW), .HOPS(HOPS)) u0 (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_data(loc_data),
    .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_data(lnk_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .ev_loc(ev_loc), .ev_lnk_in(ev_lnk_in), .ev_out(ev_out)
  );

  int         n_chk = 0, n_bad = 0;
  logic [7:0] rx_d [1024];
  logic       rx_s [1024];
  logic       rx_e [1024];
  int         rx_n = 0;
  logic       both_ready_seen = 1'b0;

  // Byte collector and ready monitor, sampled mid-cycle.
  initial forever begin
    @(negedge clk); #1;
    if (!rst && out_valid && out_ready && rx_n < 1024) begin
      rx_d[rx_n] = out_data; rx_s[rx_n] = out_sop; rx_e[rx_n] = out_eop;
      rx_n++;
    end
    if (!rst && loc_ready && lnk_ready) both_ready_seen = 1'b1;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R2: got 0 expected 1 (run did not complete)");
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(input int tag, input int prio, input int k);
    logic [7:0] t, p, kk;
    t = 8'(tag); p = 8'(prio); kk = 8'(k);
    if (k == 0) return {t[5:0], p[1:0]};
    return {t[4:0], kk[2:0]};
  endfunction

  task automatic send_pkt(input bit lnk, input int tag, input int prio);
    for (int k = 0; k < PB; k++) begin
      @(negedge clk);
      if (lnk) begin lnk_valid = 1'b1; lnk_data = pkt_byte(tag, prio, k); end
      else     begin loc_valid = 1'b1; loc_data = pkt_byte(tag, prio, k); end
      #1;
      while (!(lnk ? lnk_ready : loc_ready)) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    if (lnk) lnk_valid = 1'b0; else loc_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_n < n) @(negedge clk);
  endtask

  task automatic check_pkt(input int base, input int tag, input int prio, input string req);
    int bad_k = -1;
    int act, exp;
    for (int k = 0; k < PB; k++) begin
      if (bad_k < 0 && (rx_d[base+k] !== pkt_byte(tag, prio, k) ||
                        rx_s[base+k] !== (k == 0) || rx_e[base+k] !== (k == PB-1)))
        bad_k = k;
    end
    exp = {tag, 8'(bad_k < 0 ? 0 : bad_k)};
    act = (bad_k < 0) ? exp : {int'(rx_d[base+bad_k][7:2]), 8'(bad_k)};
    chk(bad_k < 0, req, act, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(ev_out == '0, "R1 ev_out", int'(ev_out), 0);
    chk(!loc_ready && !lnk_ready, "R1 ready idle", int'({loc_ready, lnk_ready}), 0);
  endtask

  task automatic t_basic();
    int base = rx_n;
    out_ready = 1'b1;
    send_pkt(1'b0, 1, 1);
    wait_rx(base + 8);
    check_pkt(base, 1, 1, "R2 local packet");
    send_pkt(1'b1, 2, 3);
    wait_rx(base + 16);
    check_pkt(base + 8, 2, 3, "R2 link packet");
  endtask

  task automatic t_overtake();
    int base = rx_n;
    out_ready = 1'b0;
    send_pkt(1'b0, 3, 0);
    send_pkt(1'b0, 4, 1);
    send_pkt(1'b0, 5, 3);
    send_pkt(1'b0, 6, 2);
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    wait_rx(base + 32);
    check_pkt(base,      3, 0, "R5 started packet finishes first");
    check_pkt(base + 8,  5, 3, "R3 priority 3 first");
    check_pkt(base + 16, 6, 2, "R3 priority 2 next");
    check_pkt(base + 24, 4, 1, "R3 priority 1 last");
  endtask

  task automatic t_fifo();
    int base = rx_n;
    out_ready = 1'b0;
    send_pkt(1'b0, 7, 0);
    send_pkt(1'b1, 8, 2);
    send_pkt(1'b0, 9, 2);
    @(negedge clk);
    out_ready = 1'b1;
    wait_rx(base + 24);
    check_pkt(base,      7, 0, "R5 head packet");
    check_pkt(base + 8,  8, 2, "R4 first of equal priority");
    check_pkt(base + 16, 9, 2, "R4 second of equal priority");
  endtask

  task automatic t_full();
    int base = rx_n;
    int hi = 0;
    out_ready = 1'b0;
    send_pkt(1'b0, 10, 0);
    send_pkt(1'b0, 11, 1);
    send_pkt(1'b0, 12, 1);
    @(negedge clk);
    loc_valid = 1'b1; loc_data = pkt_byte(13, 1, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (loc_ready) hi++;
    end
    chk(hi == 0, "R6 full queue refuses", hi, 0);
    send_pkt(1'b1, 14, 2);
    chk(rx_n == base, "R6 output still held", rx_n - base, 0);
    fork
      send_pkt(1'b0, 13, 1);
      begin @(negedge clk); out_ready = 1'b1; end
    join
    wait_rx(base + 40);
    check_pkt(base,      10, 0, "R5 head packet");
    check_pkt(base + 8,  14, 2, "R6 other priority passes");
    check_pkt(base + 16, 11, 1, "R4 held queue order");
    check_pkt(base + 24, 12, 1, "R4 held queue order");
    check_pkt(base + 32, 13, 1, "R6 refused packet not dropped");
  endtask

  task automatic t_alternate();
    int base = rx_n;
    int alt_bad = 0;
    out_ready = 1'b1;
    fork
      begin send_pkt(1'b0, 20, 0); send_pkt(1'b0, 21, 0); end
      begin send_pkt(1'b1, 22, 0); send_pkt(1'b1, 23, 0); end
    join
    wait_rx(base + 32);
    for (int i = 0; i < 3; i++) begin
      if ((rx_d[base + 8*i][7:2] >= 22) == (rx_d[base + 8*i + 8][7:2] >= 22)) alt_bad++;
    end
    chk(alt_bad == 0, "R8 sources alternate", alt_bad, 0);
    chk(!both_ready_seen, "R8 one ready at a time", int'(both_ready_seen), 0);
    for (int i = 0; i < 4; i++) begin
      int t = int'(rx_d[base + 8*i][7:2]);
      check_pkt(base + 8*i, t, 0, "R2 alternating packet intact");
    end
  endtask

  task automatic t_event();
    int base = rx_n;
    logic [EW-1:0] exp_ev [16];
    out_ready = 1'b1;
    fork
      send_pkt(1'b1, 30, 3);
      begin
        for (int i = 0; i < 16 + HOPS; i++) begin
          @(negedge clk);
          if (i < 16) begin
            ev_lnk_in = EW'(i * 5 + 3);
            ev_loc    = (i == 7) ? EW'(8) : EW'(0);
            exp_ev[i] = ev_lnk_in | ev_loc;
          end else begin
            ev_lnk_in = '0; ev_loc = '0;
          end
          #1;
          if (i >= HOPS) chk(ev_out == exp_ev[i-HOPS], "R9 event delay", int'(ev_out), int'(exp_ev[i-HOPS]));
        end
      end
    join
    wait_rx(base + 8);
    check_pkt(base, 30, 3, "R2 packet beside events");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_overtake();
    t_fifo();
    t_full();
    t_alternate();
    t_event();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule